// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state changes that a small 32-bit soft processor makes when it enters a trap handler. Each clock cycle in which `evt_valid` is high, the pipeline presents up to five request lines: translation fault, hardware exception, hardware break, software break and external interrupt. It also presents the context of the instruction being interrupted: the program counter, whether the instruction sits in a branch delay slot, whether an immediate prefix is pending, the branch target and the fault details. The block picks one event and commits everything for it on that clock edge. It produces a program-counter redirect and one link-register write for the register file. It also updates the machine status, exception status, exception address and branch target registers, and it emits a pulse that tells the pipeline to drop its delay-slot and prefix flags.

All outputs are registered. The result of a strobe appears in the cycle after the edge on which it was sampled. The status registers are held inside the block. Outside event cycles, the pipeline can load the machine status register through a dedicated write port.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several request lines are high in one strobe, only one event is taken. The order is translation fault first, then hardware exception, then hardware break, then software break, then interrupt.
- R2: An interrupt request is taken only when msr bit 1 (interrupt enable) is 1, msr bit 9 (exception in progress) is 0, msr bit 3 (break in progress) is 0, and neither `in_dslot` nor `imm_pending` is high. Otherwise it produces no redirect and no register change.
- R3: The redirect target is `base_vec`+0x10 for an interrupt, `base_vec`+0x18 for a hardware break, and `base_vec`+0x20 for a hardware exception or translation fault. For a software break it is `branch_target`.
- R4: On every taken event, msr bit 14 receives the old bit 13 (translation on), msr bit 12 receives the old bit 11 (user mode), and bits 13 and 11 are cleared.
- R5: A hardware exception or translation fault sets msr bit 9. Either kind of break sets msr bit 3. An interrupt clears msr bit 1.
- R6: The link write goes to register 14 with the PC for an interrupt, and to register 16 with the PC for a hardware break. A hardware exception writes PC+4 to register 17, and a translation fault writes its adjusted PC (R7) to register 17. A software break makes no link write.
- R7: For a translation fault, the link value is PC-8 in a delay slot whose branch carried a prefix, and PC-4 in any other delay slot. Outside a delay slot it is PC-4 with a pending prefix, else PC.
- R8: A translation fault overwrites esr as follows. Bits 4:0 hold the cause: 16 for data protection, 17 for fetch protection, 18 for data miss, 19 for fetch miss. Bit 10 holds `fault_store` and bit 12 holds `in_dslot`. A hardware exception changes only esr bit 12, to `in_dslot`. For both kinds, btr is loaded with `branch_target` when `in_dslot` is high.
- R9: A taken translation fault loads ear with `fault_addr`. No other event changes ear.
- R10: When `exc_supported` is low, the hardware exception request is ignored, and lower-priority requests in the same strobe are considered as if it were absent.
- R11: `flags_clr` pulses for one cycle after a taken hardware exception or translation fault, and at no other time.
- R12: A translation fault arriving while msr bit 9 is set and the last taken event was a translation fault is a recursive fault. It sets `busy`, which stays set until reset, and it commits no other change.
- R13: In a cycle without a selected event, `msr_wr_en` loads msr with `msr_wr_data`. When an event is selected in the same cycle, the write is dropped.
- R14: After reset, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event strobe qualifying the request lines |
| evt_tfault | input | 1 | Translation fault request |
| evt_hwexc | input | 1 | Hardware exception request |
| evt_hwbrk | input | 1 | Hardware break request |
| evt_swbrk | input | 1 | Software break request |
| evt_irq | input | 1 | External interrupt request |
| exc_supported | input | 1 | Configuration: hardware exceptions implemented |
| cur_pc | input | 32 | PC of the interrupted instruction |
| base_vec | input | 32 | Vector base address |
| branch_target | input | 32 | Pending branch target |
| in_dslot | input | 1 | Instruction is in a branch delay slot |
| imm_pending | input | 1 | Immediate prefix pending |
| branch_had_imm | input | 1 | The delay-slot branch carried a prefix |
| fault_addr | input | 32 | Faulting address |
| fault_prot | input | 1 | Fault is protection (1) or miss (0) |
| fault_fetch | input | 1 | Fault on instruction fetch (1) or data (0) |
| fault_store | input | 1 | Faulting data access was a store |
| msr_wr_en | input | 1 | Load msr from the pipeline |
| msr_wr_data | input | 32 | Value for msr load |
| redirect_valid | output | 1 | PC redirect pulse |
| redirect_pc | output | 32 | Handler address |
| rf_we | output | 1 | Link register write pulse |
| rf_waddr | output | 5 | Link register index |
| rf_wdata | output | 32 | Link value |
| msr | output | 32 | Machine status register |
| esr | output | 32 | Exception status register |
| ear | output | 32 | Exception address register |
| btr | output | 32 | Branch target register |
| flags_clr | output | 1 | Clear delay-slot and prefix flags pulse |
| busy | output | 1 | Recursive translation fault seen |

## Verification
The hardest state to reach from the ports is the recursive fault. It needs msr bit 9 still set from an earlier translation fault, and no other event may have been taken in between. The bench builds this with two back-to-back directed fault strobes. Random traffic reaches it only occasionally, because random msr loads often clear bit 9. The prefix-in-delay-slot return adjustment is also rare under random flags, so a directed fault with `in_dslot` and `branch_had_imm` both high covers the PC-8 case.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [2:0] {
    EV_NONE, EV_TFAULT, EV_HWEXC, EV_HWBRK, EV_SWBRK, EV_IRQ
  } ev_kind_t;

  // machine status bit positions; saved copies sit one above the live bits
  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = MSR_UM + 1;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = MSR_VM + 1;

  localparam int ESR_STORE = 10;
  localparam int ESR_DS    = 12;

  localparam int OFF_IRQ = 'h10;
  localparam int OFF_BRK = 'h18;
  localparam int OFF_EXC = 'h20;

  localparam int LINK_IRQ = 14;
  localparam int LINK_BRK = 16;
  localparam int LINK_EXC = 17;

  localparam logic [4:0] CAUSE_PROT_DATA  = 5'd16;
  localparam logic [4:0] CAUSE_PROT_FETCH = 5'd17;
  localparam logic [4:0] CAUSE_MISS_DATA  = 5'd18;
  localparam logic [4:0] CAUSE_MISS_FETCH = 5'd19;
endpackage

// File: rtl/ent_arbiter.sv
module ent_arbiter
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            strobe,
  input  logic            rq_tfault,
  input  logic            rq_hwexc,
  input  logic            rq_hwbrk,
  input  logic            rq_swbrk,
  input  logic            rq_irq,
  input  logic            exc_on,
  input  logic [XLEN-1:0] cur_msr,
  input  logic            dslot,
  input  logic            imm,
  output ev_kind_t        kind
);
  logic irq_ok;
  logic hwexc_ok;

  always_comb begin
    irq_ok   = rq_irq && cur_msr[MSR_IE] && !cur_msr[MSR_EIP] &&
               !cur_msr[MSR_BIP] && !dslot && !imm;
    hwexc_ok = rq_hwexc && exc_on;
    kind     = EV_NONE;
    if (strobe) begin
      if (rq_tfault)     kind = EV_TFAULT;
      else if (hwexc_ok) kind = EV_HWEXC;
      else if (rq_hwbrk) kind = EV_HWBRK;
      else if (rq_swbrk) kind = EV_SWBRK;
      else if (irq_ok)   kind = EV_IRQ;
    end
  end
endmodule

// File: rtl/ent_retaddr.sv
module ent_retaddr
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  ev_kind_t          kind,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   base,
  input  logic [XLEN-1:0]   btarget,
  input  logic              dslot,
  input  logic              imm,
  input  logic              br_imm,
  output logic [XLEN-1:0]   target,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic [XLEN-1:0] rewind;

  always_comb begin
    if (dslot)    rewind = br_imm ? (WORD << 1) : WORD;
    else if (imm) rewind = WORD;
    else          rewind = '0;
  end

  always_comb begin
    target   = '0;
    link_we  = 1'b0;
    link_idx = '0;
    link_val = '0;
    unique case (kind)
      EV_IRQ: begin
        target   = base + XLEN'(OFF_IRQ);
        link_we  = 1'b1;
        link_idx = RIDX_W'(LINK_IRQ);
        link_val = pc;
      end
      EV_HWBRK: begin
        target   = base + XLEN'(OFF_BRK);
        link_we  = 1'b1;
        link_idx = RIDX_W'(LINK_BRK);
        link_val = pc;
      end
      EV_SWBRK: target = btarget;
      EV_HWEXC: begin
        target   = base + XLEN'(OFF_EXC);
        link_we  = 1'b1;
        link_idx = RIDX_W'(LINK_EXC);
        link_val = pc + WORD;
      end
      EV_TFAULT: begin
        target   = base + XLEN'(OFF_EXC);
        link_we  = 1'b1;
        link_idx = RIDX_W'(LINK_EXC);
        link_val = pc - rewind;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ent_status.sv
module ent_status
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  ev_kind_t        kind,
  input  logic            dslot,
  input  logic [XLEN-1:0] btarget,
  input  logic [XLEN-1:0] f_addr,
  input  logic            f_prot,
  input  logic            f_fetch,
  input  logic            f_store,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic            nest,
  output logic [XLEN-1:0] msr_q,
  output logic [XLEN-1:0] esr_q,
  output logic [XLEN-1:0] ear_q,
  output logic [XLEN-1:0] btr_q,
  output logic            busy_q
);
  logic            last_tf_q;
  logic            commit;
  logic [XLEN-1:0] msr_nx;
  logic [XLEN-1:0] esr_nx;
  logic [4:0]      cause;
  logic            is_exc;

  assign is_exc = (kind == EV_TFAULT) || (kind == EV_HWEXC);
  assign nest   = (kind == EV_TFAULT) && msr_q[MSR_EIP] && last_tf_q;
  assign commit = (kind != EV_NONE) && !nest;

  always_comb begin
    if (f_prot) cause = f_fetch ? CAUSE_PROT_FETCH : CAUSE_PROT_DATA;
    else        cause = f_fetch ? CAUSE_MISS_FETCH : CAUSE_MISS_DATA;
  end

  always_comb begin
    msr_nx          = msr_q;
    msr_nx[MSR_VMS] = msr_q[MSR_VM];
    msr_nx[MSR_UMS] = msr_q[MSR_UM];
    msr_nx[MSR_VM]  = 1'b0;
    msr_nx[MSR_UM]  = 1'b0;
    case (kind)
      EV_TFAULT, EV_HWEXC: msr_nx[MSR_EIP] = 1'b1;
      EV_HWBRK, EV_SWBRK:  msr_nx[MSR_BIP] = 1'b1;
      EV_IRQ:              msr_nx[MSR_IE]  = 1'b0;
      default: ;
    endcase
  end

  always_comb begin
    esr_nx = esr_q;
    if (kind == EV_TFAULT) begin
      esr_nx            = '0;
      esr_nx[4:0]       = cause;
      esr_nx[ESR_STORE] = f_store;
      esr_nx[ESR_DS]    = dslot;
    end else if (kind == EV_HWEXC) begin
      esr_nx[ESR_DS] = dslot;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q     <= '0;
      esr_q     <= '0;
      ear_q     <= '0;
      btr_q     <= '0;
      busy_q    <= 1'b0;
      last_tf_q <= 1'b0;
    end else if (commit) begin
      msr_q     <= msr_nx;
      esr_q     <= esr_nx;
      last_tf_q <= (kind == EV_TFAULT);
      if (kind == EV_TFAULT) ear_q <= f_addr;
      if (is_exc && dslot)   btr_q <= btarget;
    end else if (nest) begin
      busy_q <= 1'b1;
    end else if (wr_en && kind == EV_NONE) begin
      msr_q <= wr_data;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_valid,
  input  logic              evt_tfault,
  input  logic              evt_hwexc,
  input  logic              evt_hwbrk,
  input  logic              evt_swbrk,
  input  logic              evt_irq,
  input  logic              exc_supported,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   base_vec,
  input  logic [XLEN-1:0]   branch_target,
  input  logic              in_dslot,
  input  logic              imm_pending,
  input  logic              branch_had_imm,
  input  logic [XLEN-1:0]   fault_addr,
  input  logic              fault_prot,
  input  logic              fault_fetch,
  input  logic              fault_store,
  input  logic              msr_wr_en,
  input  logic [XLEN-1:0]   msr_wr_data,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [XLEN-1:0]   rf_wdata,
  output logic [XLEN-1:0]   msr,
  output logic [XLEN-1:0]   esr,
  output logic [XLEN-1:0]   ear,
  output logic [XLEN-1:0]   btr,
  output logic              flags_clr,
  output logic              busy
);
  ev_kind_t          kind;
  logic              nest;
  logic [XLEN-1:0]   tgt;
  logic              lk_we;
  logic [RIDX_W-1:0] lk_idx;
  logic [XLEN-1:0]   lk_val;
  logic              take;

  ent_arbiter #(.XLEN(XLEN)) u_arb (
    .strobe   (evt_valid),
    .rq_tfault(evt_tfault),
    .rq_hwexc (evt_hwexc),
    .rq_hwbrk (evt_hwbrk),
    .rq_swbrk (evt_swbrk),
    .rq_irq   (evt_irq),
    .exc_on   (exc_supported),
    .cur_msr  (msr),
    .dslot    (in_dslot),
    .imm      (imm_pending),
    .kind     (kind)
  );

  ent_retaddr #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_ret (
    .kind    (kind),
    .pc      (cur_pc),
    .base    (base_vec),
    .btarget (branch_target),
    .dslot   (in_dslot),
    .imm     (imm_pending),
    .br_imm  (branch_had_imm),
    .target  (tgt),
    .link_we (lk_we),
    .link_idx(lk_idx),
    .link_val(lk_val)
  );

  ent_status #(.XLEN(XLEN)) u_st (
    .clk    (clk),
    .rst    (rst),
    .kind   (kind),
    .dslot  (in_dslot),
    .btarget(branch_target),
    .f_addr (fault_addr),
    .f_prot (fault_prot),
    .f_fetch(fault_fetch),
    .f_store(fault_store),
    .wr_en  (msr_wr_en),
    .wr_data(msr_wr_data),
    .nest   (nest),
    .msr_q  (msr),
    .esr_q  (esr),
    .ear_q  (ear),
    .btr_q  (btr),
    .busy_q (busy)
  );

  assign take = (kind != EV_NONE) && !nest;

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      rf_we          <= 1'b0;
      rf_waddr       <= '0;
      rf_wdata       <= '0;
      flags_clr      <= 1'b0;
    end else begin
      redirect_valid <= take;
      rf_we          <= take && lk_we;
      flags_clr      <= take && (kind == EV_TFAULT || kind == EV_HWEXC);
      if (take) begin
        redirect_pc <= tgt;
        rf_waddr    <= lk_idx;
        rf_wdata    <= lk_val;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_valid,
  input logic              evt_tfault,
  input logic              evt_hwexc,
  input logic              evt_hwbrk,
  input logic              evt_swbrk,
  input logic              evt_irq,
  input logic [XLEN-1:0]   base_vec,
  input logic              redirect_valid,
  input logic [XLEN-1:0]   redirect_pc,
  input logic              rf_we,
  input logic [RIDX_W-1:0] rf_waddr,
  input logic [XLEN-1:0]   msr,
  input logic              flags_clr,
  input logic              busy
);
  p_irq_vec_r3: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && rf_we && rf_waddr == RIDX_W'(LINK_IRQ))
      |-> redirect_pc == $past(base_vec) + XLEN'(OFF_IRQ));

  p_irq_block_r2: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && evt_irq && !evt_tfault && !evt_hwexc && !evt_hwbrk &&
     !evt_swbrk && (msr[MSR_EIP] || msr[MSR_BIP])) |=> !redirect_valid);

  p_mode_off_r4: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (!msr[MSR_VM] && !msr[MSR_UM]));

  p_mode_save_r4: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> (msr[MSR_VMS] == $past(msr[MSR_VM]) &&
                        msr[MSR_UMS] == $past(msr[MSR_UM])));

  p_flags_r11: assert property (@(posedge clk) disable iff (rst)
    flags_clr |-> (redirect_valid && msr[MSR_EIP]));

  p_busy_hold_r12: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy);

  p_busy_cause_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(evt_valid && evt_tfault) && !redirect_valid));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .evt_valid     (evt_valid),
  .evt_tfault    (evt_tfault),
  .evt_hwexc     (evt_hwexc),
  .evt_hwbrk     (evt_hwbrk),
  .evt_swbrk     (evt_swbrk),
  .evt_irq       (evt_irq),
  .base_vec      (base_vec),
  .redirect_valid(redirect_valid),
  .redirect_pc   (redirect_pc),
  .rf_we         (rf_we),
  .rf_waddr      (rf_waddr),
  .msr           (msr),
  .flags_clr     (flags_clr),
  .busy          (busy)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic evt_valid = 0, evt_tfault = 0, evt_hwexc = 0, evt_hwbrk = 0;
  logic evt_swbrk = 0, evt_irq = 0, exc_supported = 1;
  logic [31:0] cur_pc = 0, base_vec = 0, branch_target = 0, fault_addr = 0;
  logic in_dslot = 0, imm_pending = 0, branch_had_imm = 0;
  logic fault_prot = 0, fault_fetch = 0, fault_store = 0;
  logic msr_wr_en = 0;
  logic [31:0] msr_wr_data = 0;
  logic        redirect_valid, rf_we, flags_clr, busy;
  logic [31:0] redirect_pc, rf_wdata, msr, esr, ear, btr;
  logic [4:0]  rf_waddr;

  exc_entry_ctrl u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [31:0] m_msr, m_esr, m_ear, m_btr, e_pc, e_wd;
  logic        m_busy, m_ltf, e_rv, e_we, e_fc;
  logic [4:0]  e_wa;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected effect of the current inputs, computed from the requirements
  task automatic model();
    int k;
    logic [31:0] nm;
    k = 0;
    e_rv = 0; e_we = 0; e_fc = 0;
    if (evt_valid) begin
      if (evt_tfault) k = 1;
      else if (evt_hwexc && exc_supported) k = 2;
      else if (evt_hwbrk) k = 3;
      else if (evt_swbrk) k = 4;
      else if (evt_irq && m_msr[1] && !m_msr[9] && !m_msr[3] &&
               !in_dslot && !imm_pending) k = 5;
    end
    if (k == 1 && m_msr[9] && m_ltf) begin
      m_busy = 1;
    end else if (k != 0) begin
      e_rv = 1;
      nm = m_msr;
      nm[14] = m_msr[13]; nm[12] = m_msr[11]; nm[13] = 0; nm[11] = 0;
      if (k <= 2) nm[9] = 1;
      else if (k <= 4) nm[3] = 1;
      else nm[1] = 0;
      m_msr = nm;
      m_ltf = (k == 1);
      case (k)
        1: begin
          e_pc = base_vec + 32'h20; e_we = 1; e_wa = 17; e_fc = 1;
          e_wd = cur_pc - (in_dslot ? (branch_had_imm ? 8 : 4) : (imm_pending ? 4 : 0));
          m_esr = {19'd0, in_dslot, 1'b0, fault_store, 5'd0,
                   5'd16 + {3'd0, !fault_prot, fault_fetch}};
          m_ear = fault_addr;
          if (in_dslot) m_btr = branch_target;
        end
        2: begin
          e_pc = base_vec + 32'h20; e_we = 1; e_wa = 17; e_fc = 1;
          e_wd = cur_pc + 4;
          m_esr[12] = in_dslot;
          if (in_dslot) m_btr = branch_target;
        end
        3: begin e_pc = base_vec + 32'h18; e_we = 1; e_wa = 16; e_wd = cur_pc; end
        4: begin e_pc = branch_target; end
        default: begin e_pc = base_vec + 32'h10; e_we = 1; e_wa = 14; e_wd = cur_pc; end
      endcase
    end else if (msr_wr_en) begin
      m_msr = msr_wr_data;
    end
  endtask

  task automatic step();
    model();
    @(posedge clk);
    #1;
    chk("R1 redirect_valid", {31'd0, redirect_valid}, {31'd0, e_rv});
    chk("R11 flags_clr", {31'd0, flags_clr}, {31'd0, e_fc});
    chk("R6 rf_we", {31'd0, rf_we}, {31'd0, e_rv && e_we});
    if (e_rv) chk("R3 redirect_pc", redirect_pc, e_pc);
    if (e_rv && e_we) begin
      chk("R6 rf_waddr", {27'd0, rf_waddr}, {27'd0, e_wa});
      chk("R7 rf_wdata", rf_wdata, e_wd);
    end
    chk("R5 msr", msr, m_msr);
    chk("R8 esr", esr, m_esr);
    chk("R9 ear", ear, m_ear);
    chk("R8 btr", btr, m_btr);
    chk("R12 busy", {31'd0, busy}, {31'd0, m_busy});
    evt_valid = 0; evt_tfault = 0; evt_hwexc = 0; evt_hwbrk = 0;
    evt_swbrk = 0; evt_irq = 0; msr_wr_en = 0;
    @(negedge clk);
  endtask

  task automatic ctx(logic [31:0] pc, logic ds, logic im, logic bi);
    cur_pc = pc; in_dslot = ds; imm_pending = im; branch_had_imm = bi;
  endtask

  task automatic wr_msr(logic [31:0] v);
    msr_wr_en = 1; msr_wr_data = v; step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc_before;
    m_msr = 0; m_esr = 0; m_ear = 0; m_btr = 0; m_busy = 0; m_ltf = 0;
    e_pc = 0; e_wd = 0; e_wa = 0; e_rv = 0; e_we = 0; e_fc = 0;
    base_vec = 32'h0000_1000; branch_target = 32'h0000_4440;
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    // R14 reset state
    chk("R14 msr", msr, 0);
    chk("R14 esr", esr, 0);
    chk("R14 redirect_valid", {31'd0, redirect_valid}, 0);
    chk("R14 busy", {31'd0, busy}, 0);
    @(negedge clk);

    // R13 msr load with VM, UM, IE set
    wr_msr(32'h0000_2802);
    chk("R13 msr loaded", msr, 32'h0000_2802);

    // interrupt accepted: vector, r14, IE cleared, modes saved (R4)
    ctx(32'h0000_0200, 0, 0, 0);
    evt_valid = 1; evt_irq = 1; step();
    chk("R4 modes saved", msr, 32'h0000_5000);
    chk("R3 irq vector", redirect_pc, 32'h0000_1010);

    // R2 interrupt refused when IE clear
    evt_valid = 1; evt_irq = 1; step();
    chk("R2 no redirect ie=0", {31'd0, redirect_valid}, 0);
    // R2 refused with prefix pending, then with delay slot
    wr_msr(32'h0000_0002);
    ctx(32'h0000_0300, 0, 1, 0);
    evt_valid = 1; evt_irq = 1; step();
    chk("R2 no redirect imm", {31'd0, redirect_valid}, 0);
    ctx(32'h0000_0300, 1, 0, 0);
    evt_valid = 1; evt_irq = 1; step();
    chk("R2 no redirect dslot", {31'd0, redirect_valid}, 0);
    chk("R2 msr untouched", msr, 32'h0000_0002);

    // R10 unsupported hardware exception ignored, swbrk below it wins
    exc_supported = 0;
    ctx(32'h0000_0400, 0, 0, 0);
    evt_valid = 1; evt_hwexc = 1; step();
    chk("R10 hwexc ignored", {31'd0, redirect_valid}, 0);
    chk("R10 esr untouched", esr, 0);
    evt_valid = 1; evt_hwexc = 1; evt_swbrk = 1; step();
    chk("R10 swbrk taken", redirect_pc, 32'h0000_4440);
    exc_supported = 1;

    // R1 all requests at once: fault wins
    wr_msr(0);
    ctx(32'h0000_0500, 1, 0, 1);
    fault_addr = 32'hDEAD_0040; fault_prot = 1; fault_fetch = 0; fault_store = 1;
    evt_valid = 1; evt_tfault = 1; evt_hwexc = 1; evt_hwbrk = 1;
    evt_swbrk = 1; evt_irq = 1; step();
    chk("R1 fault wins", {27'd0, rf_waddr}, 17);
    chk("R7 dslot prefixed rewind", rf_wdata, 32'h0000_04F8);
    chk("R8 esr store prot dslot", esr, 32'h0000_1410);
    chk("R9 ear", ear, 32'hDEAD_0040);

    // R12 recursive fault
    ctx(32'h0000_0600, 0, 1, 0);
    evt_valid = 1; evt_tfault = 1; step();
    chk("R12 busy set", {31'd0, busy}, 1);
    chk("R12 ear kept", ear, 32'hDEAD_0040);

    // R1 hwbrk over swbrk and irq
    wr_msr(32'h0000_0002);
    ctx(32'h0000_0700, 0, 0, 0);
    evt_valid = 1; evt_hwbrk = 1; evt_swbrk = 1; evt_irq = 1; step();
    chk("R1 hwbrk wins", redirect_pc, 32'h0000_1018);

    // random traffic
    void'($urandom(32'h5EED));
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 9);
      ctx({$urandom_range(0, 32'hFFFF), 2'b00}, ($urandom_range(0, 3) == 0),
          ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
      base_vec = {$urandom_range(0, 255), 8'h00};
      branch_target = {$urandom, 2'b00};
      fault_addr = $urandom;
      fault_prot = $urandom_range(0, 1);
      fault_fetch = $urandom_range(0, 1);
      fault_store = $urandom_range(0, 1);
      exc_supported = ($urandom_range(0, 5) != 0);
      if (r < 2) begin
        msr_wr_en = 1;
        msr_wr_data = $urandom & 32'h0000_7A0A;
      end else begin
        evt_valid = ($urandom_range(0, 7) != 0);
        evt_tfault = ($urandom_range(0, 4) == 0);
        evt_hwexc = ($urandom_range(0, 4) == 0);
        evt_hwbrk = ($urandom_range(0, 5) == 0);
        evt_swbrk = ($urandom_range(0, 5) == 0);
        evt_irq = ($urandom_range(0, 1) == 0);
        msr_wr_en = ($urandom_range(0, 3) == 0);
        msr_wr_data = $urandom & 32'h0000_7A0A;
      end
      pc_before = cur_pc;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule